// File: doc/BRIEF.md
# CAN Transmit Mailbox Scheduler

This block sits between the transmit mailboxes of a CAN controller and its frame engine. It picks which pending mailbox goes on the wire next and tells the frame engine with a one-cycle start pulse, the mailbox index and that mailbox's identifier. After the attempt, the frame engine answers with a single result strobe: success, error or arbitration lost. The scheduler then either retires the mailbox or leaves it pending so that it is tried again.

Two run-time controls shape its behaviour. `order_by_req` chooses how pending mailboxes are ranked. At 0 the lowest identifier goes first. At 1 mailboxes go in the order their requests arrived, which the block tracks in a small age queue. `single_shot` makes every mailbox retire after one attempt, whatever the result. A debug freeze input stops new transmissions from starting, but it still lets an attempt that is already running finish.

Each mailbox has four status flags. One marks that the request completed, and the other three show the outcome of the latest attempt. Software raises a request with a one-cycle pulse on the mailbox's request bit. The scheduler clears that bit itself when the mailbox retires.

Top module: `can_tx_sched`

## Requirements
- R1: After reset, no mailbox is pending, all status flags are 0 and `tx_start` is low.
- R2: A pulse on `req_set[i]` for a mailbox that is not pending sets `pending[i]` on the next edge and clears that mailbox's done, ok, err and arb flags. A pulse for a mailbox that is already pending is ignored.
- R3: With `order_by_req`=0, the mailbox with the numerically lowest identifier is started first. On equal identifiers, the lower mailbox index wins.
- R4: With `order_by_req`=1, mailboxes start in the order their requests rose. Requests that rise in the same cycle are ordered by ascending index.
- R5: Only one transmission is in flight at a time. `tx_start` is a one-cycle pulse for a pending mailbox. `tx_idx` and `tx_id` (the identifier of the mailbox at `tx_idx`) hold until the result strobe.
- R6: A success result retires the mailbox. This clears `pending`, sets `done_flag` and `ok_flag`, and clears `err_flag` and `arb_flag` for that mailbox.
- R7: With `single_shot`=0, an error or arbitration-lost result sets the matching flag and clears the other two. The mailbox stays pending, `done_flag` stays 0, and the mailbox is started again.
- R8: With `single_shot`=1, any result retires the mailbox and sets `done_flag`. Exactly one of ok, err or arb is set, matching the result.
- R9: While `dbg_freeze` is high, no `tx_start` is issued. A result for an attempt already in flight is still accepted.
- R10: Result strobes are ignored when no transmission is in flight. When more than one strobe is high at once, success takes precedence over error, and error over arbitration lost.
- R11: A change of `order_by_req` takes effect at the next selection, including while an attempt is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| order_by_req | input | 1 | 0: lowest identifier first; 1: request order |
| single_shot | input | 1 | 1: one attempt per request |
| dbg_freeze | input | 1 | Blocks new transmissions |
| req_set | input | N | Per-mailbox request pulse |
| mb_id | input | N*IDW | Identifiers, mailbox i at bits [i*IDW +: IDW] |
| res_ok | input | 1 | Attempt succeeded |
| res_err | input | 1 | Attempt ended in error |
| res_arb | input | 1 | Attempt lost arbitration |
| tx_start | output | 1 | Pulse: start sending mailbox `tx_idx` |
| tx_idx | output | IW | Mailbox index in flight |
| tx_id | output | IDW | Identifier of mailbox `tx_idx` |
| pending | output | N | Request bits |
| done_flag | output | N | Request completed |
| ok_flag | output | N | Last attempt succeeded |
| err_flag | output | N | Last attempt ended in error |
| arb_flag | output | N | Last attempt lost arbitration |

## Verification
Two things can happen in the same cycle: a mailbox retires from the age queue, and a new request appends to it. A second case is a mode change that lands while an attempt is still in flight. The bench causes the second case by switching `order_by_req` between `tx_start` and the result, then judges it from the index of the next start, which must be the queue head and not the lowest identifier. The first case is judged by whether the later starts follow the expected chronological sequence. The bench also drives two result strobes at once and checks that the flags show the winning result.

// File: rtl/can_tx_sched.sv
module can_tx_sched #(
  parameter int N   = 3,
  parameter int IDW = 11,
  localparam int IW = (N > 1) ? $clog2(N) : 1,
  localparam int CW = $clog2(N + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           order_by_req,
  input  logic           single_shot,
  input  logic           dbg_freeze,
  input  logic [N-1:0]   req_set,
  input  logic [N*IDW-1:0] mb_id,
  input  logic           res_ok,
  input  logic           res_err,
  input  logic           res_arb,
  output logic           tx_start,
  output logic [IW-1:0]  tx_idx,
  output logic [IDW-1:0] tx_id,
  output logic [N-1:0]   pending,
  output logic [N-1:0]   done_flag,
  output logic [N-1:0]   ok_flag,
  output logic [N-1:0]   err_flag,
  output logic [N-1:0]   arb_flag
);

  logic          busy;
  logic [IW-1:0] q  [N];
  logic [IW-1:0] qn [N];
  logic [CW-1:0] qcnt, cn;
  logic [IW-1:0] best_idx, sel;
  logic [IDW-1:0] best_id;
  logic          found, hit;

  wire [N-1:0] app      = req_set & ~pending;
  wire         res_any  = busy & (res_ok | res_err | res_arb);
  wire         retire   = busy & (res_ok | (single_shot & (res_err | res_arb)));
  wire         can_start = ~busy & (|pending) & ~dbg_freeze;

  assign tx_id = mb_id[tx_idx*IDW +: IDW];
  assign sel   = order_by_req ? q[0] : best_idx;

  always_comb begin
    found    = 1'b0;
    best_idx = '0;
    best_id  = '0;
    for (int i = 0; i < N; i++) begin
      if (pending[i] && (!found || mb_id[i*IDW +: IDW] < best_id)) begin
        found    = 1'b1;
        best_idx = IW'(i);
        best_id  = mb_id[i*IDW +: IDW];
      end
    end
  end

  always_comb begin
    qn  = q;
    cn  = qcnt;
    hit = 1'b0;
    for (int k = 0; k < N - 1; k++) begin
      if (retire && k < int'(qcnt) && q[k] == tx_idx) hit = 1'b1;
      if (hit) qn[k] = q[k+1];
    end
    if (retire && qcnt != '0) cn = cn - CW'(1);
    for (int i = 0; i < N; i++) begin
      if (app[i]) begin
        for (int k = 0; k < N; k++)
          if (k == int'(cn)) qn[k] = IW'(i);
        cn = cn + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      tx_start  <= 1'b0;
      tx_idx    <= '0;
      pending   <= '0;
      done_flag <= '0;
      ok_flag   <= '0;
      err_flag  <= '0;
      arb_flag  <= '0;
      qcnt      <= '0;
      for (int k = 0; k < N; k++) q[k] <= '0;
    end else begin
      tx_start <= can_start;
      if (can_start) begin
        busy   <= 1'b1;
        tx_idx <= sel;
      end else if (res_any) begin
        busy <= 1'b0;
      end
      for (int i = 0; i < N; i++) begin
        if (app[i]) begin
          pending[i]   <= 1'b1;
          done_flag[i] <= 1'b0;
          ok_flag[i]   <= 1'b0;
          err_flag[i]  <= 1'b0;
          arb_flag[i]  <= 1'b0;
        end else if (res_any && tx_idx == IW'(i)) begin
          ok_flag[i]  <= res_ok;
          err_flag[i] <= ~res_ok & res_err;
          arb_flag[i] <= ~res_ok & ~res_err & res_arb;
          if (retire) begin
            pending[i]   <= 1'b0;
            done_flag[i] <= 1'b1;
          end
        end
      end
      q    <= qn;
      qcnt <= cn;
    end
  end

endmodule

module can_tx_sched_chk #(
  parameter int N  = 3,
  parameter int IW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          single_shot,
  input logic          dbg_freeze,
  input logic          res_ok,
  input logic          res_err,
  input logic          res_arb,
  input logic          tx_start,
  input logic [IW-1:0] tx_idx,
  input logic [N-1:0]  pending,
  input logic [N-1:0]  done_flag
);

  // R9
  start_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> !$past(dbg_freeze));

  // R5
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> !tx_start);

  // R5
  start_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> (busy && pending[tx_idx]));

  // R8
  single_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && single_shot && (res_ok || res_err || res_arb)) |=>
      (!pending[$past(tx_idx)] && done_flag[$past(tx_idx)]));

  // R7
  retry_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !single_shot && !res_ok && (res_err || res_arb)) |=>
      (pending[$past(tx_idx)] && !done_flag[$past(tx_idx)]));

  // R10
  idle_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> ((done_flag & ~$past(done_flag)) == '0));

endmodule

bind can_tx_sched can_tx_sched_chk #(.N(N), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .single_shot(single_shot),
  .dbg_freeze(dbg_freeze), .res_ok(res_ok), .res_err(res_err),
  .res_arb(res_arb), .tx_start(tx_start), .tx_idx(tx_idx),
  .pending(pending), .done_flag(done_flag)
);

// File: tb/can_tx_sched_tb.sv
module can_tx_sched_tb;
  localparam int N = 3, IDW = 11;

  logic clk = 0, rst_n = 0;
  logic order_by_req = 0, single_shot = 0, dbg_freeze = 0;
  logic [N-1:0] req_set = '0;
  logic [N*IDW-1:0] mb_id;
  logic res_ok = 0, res_err = 0, res_arb = 0;
  logic tx_start;
  logic [1:0] tx_idx;
  logic [IDW-1:0] tx_id;
  logic [N-1:0] pending, done_flag, ok_flag, err_flag, arb_flag;

  logic [IDW-1:0] ids [N];
  int compared = 0, mismatched = 0;

  always #4 clk = ~clk;
  assign mb_id = {ids[2], ids[1], ids[0]};

  can_tx_sched #(.N(N), .IDW(IDW)) u_dut (.*);

  task automatic chk(string tag, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic request(logic [N-1:0] m);
    @(negedge clk); req_set = m;
    @(negedge clk); req_set = '0;
  endtask

  task automatic quiet(string tag, int cyc);
    for (int c = 0; c < cyc; c++) begin
      @(negedge clk);
      chk(tag, tx_start, 0);
    end
  endtask

  task automatic wait_start(string tag, int exp);
    int n = 0;
    @(negedge clk);
    while (!tx_start && n < 30) begin @(negedge clk); n++; end
    chk({tag, " start seen"}, tx_start, 1);
    chk({tag, " tx_idx"}, tx_idx, exp);
    chk({tag, " tx_id"}, tx_id, ids[exp]);
  endtask

  task automatic result(logic ok, logic er, logic ar);
    res_ok = ok; res_err = er; res_arb = ar;
    @(negedge clk);
    res_ok = 0; res_err = 0; res_arb = 0;
  endtask

  task automatic flags(string tag, int p, int d, int o, int e, int a);
    chk({tag, " pending"}, pending, p);
    chk({tag, " done"}, done_flag, d);
    chk({tag, " ok"}, ok_flag, o);
    chk({tag, " err"}, err_flag, e);
    chk({tag, " arb"}, arb_flag, a);
  endtask

  task automatic t_reset;
    @(negedge clk);
    flags("R1 reset", 0, 0, 0, 0, 0);
    chk("R1 tx_start", tx_start, 0);
  endtask

  task automatic t_id_mode;
    order_by_req = 0; single_shot = 0; dbg_freeze = 1;
    request(3'b111);
    flags("R2 set", 7, 0, 0, 0, 0);
    quiet("R9 frozen", 4);
    dbg_freeze = 0;
    wait_start("R3 tie low idx", 1); result(1, 0, 0);
    wait_start("R3 second", 2);      result(1, 0, 0);
    wait_start("R3 highest id", 0);  result(1, 0, 0);
    flags("R6 all ok", 0, 7, 7, 0, 0);
  endtask

  task automatic t_order_mode;
    order_by_req = 1; dbg_freeze = 1;
    request(3'b100); request(3'b001); request(3'b010);
    dbg_freeze = 0;
    wait_start("R4 first", 2);  result(1, 0, 0);
    wait_start("R4 second", 0); result(1, 0, 0);
    wait_start("R4 third", 1);  result(1, 0, 0);
    dbg_freeze = 1;
    request(3'b110); request(3'b001);
    dbg_freeze = 0;
    wait_start("R4 same cycle a", 1); result(1, 0, 0);
    wait_start("R4 same cycle b", 2); result(1, 0, 0);
    wait_start("R4 later", 0);        result(1, 0, 0);
    quiet("R5 idle", 3);
  endtask

  task automatic t_retry;
    order_by_req = 0; single_shot = 0;
    request(3'b001);
    wait_start("R7 try1", 0); result(0, 1, 0);
    flags("R7 after err", 1, 6, 6, 1, 0);
    wait_start("R7 try2", 0); result(0, 0, 1);
    flags("R7 after arb", 1, 6, 6, 0, 1);
    wait_start("R7 try3", 0); result(1, 0, 0);
    flags("R6 after retry ok", 0, 7, 7, 0, 0);
  endtask

  task automatic t_single;
    single_shot = 1; dbg_freeze = 1;
    request(3'b111);
    dbg_freeze = 0;
    wait_start("R8 a", 1); result(0, 1, 0);
    wait_start("R8 b", 2); result(0, 0, 1);
    wait_start("R8 c", 0); result(1, 0, 0);
    flags("R8 retired", 0, 7, 1, 2, 4);
    quiet("R8 no retry", 4);
    single_shot = 0;
  endtask

  task automatic t_ignore;
    result(1, 1, 1);
    @(negedge clk);
    flags("R10 idle strobes", 0, 7, 1, 2, 4);
    dbg_freeze = 1;
    request(3'b010);
    flags("R2 status cleared", 2, 5, 1, 0, 4);
    order_by_req = 1;
    request(3'b001); request(3'b010);
    dbg_freeze = 0;
    wait_start("R2 dup ignored a", 1); result(1, 0, 0);
    wait_start("R2 dup ignored b", 0); result(1, 0, 0);
    quiet("R2 no third", 4);
  endtask

  task automatic t_priority;
    order_by_req = 0;
    request(3'b100);
    wait_start("R10 prio", 2); result(1, 1, 1);
    flags("R10 ok wins", 0, 7, 7, 0, 0);
    request(3'b001);
    wait_start("R10 prio2", 0); result(0, 1, 1);
    flags("R10 err over arb", 1, 6, 6, 1, 0);
    wait_start("R10 retry", 0); result(1, 0, 0);
  endtask

  task automatic t_switch;
    order_by_req = 0; dbg_freeze = 1;
    request(3'b001); request(3'b100); request(3'b010);
    dbg_freeze = 0;
    wait_start("R11 id first", 1);
    order_by_req = 1;
    result(1, 0, 0);
    wait_start("R11 queue head", 0);
    dbg_freeze = 1;
    result(1, 0, 0);
    flags("R9 inflight accepted", 4, 3, 3, 0, 0);
    quiet("R9 frozen after", 4);
    dbg_freeze = 0;
    wait_start("R11 last", 2); result(1, 0, 0);
    flags("R11 end", 0, 7, 7, 0, 0);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin @(posedge clk); cyc++; end
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    ids[0] = 11'h300; ids[1] = 11'h100; ids[2] = 11'h100;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_id_mode();
    t_order_mode();
    t_retry();
    t_single();
    t_ignore();
    t_priority();
    t_switch();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule